// File: doc/BRIEF.md
# Buffered Auto-Reload Timer Channel Control

This block holds five down-counters and the one control word that drives them. Software writes a count buffer for each channel. A compare buffer exists for channels 0 to 3. A rising edge on a channel's manual-update bit copies its count buffer into the live counter. A rising edge on its start bit sets it running, and a falling edge on that bit halts it.

A running channel moves down by one on each cycle in which its tick strobe is high. A tick that arrives while the counter already holds zero is an expiry. An expiry raises a one-cycle expire pulse toward the interrupt logic. Then one of two things happens. With auto-reload set, the counter refills from its count buffer and keeps running. Without it, the counter rests at zero and its start bit drops out of the control word.

A simple register port reaches everything: two configuration words, the control word, the buffers, and a read-only view of each live counter. Reads return data combinationally from the address. Writes take effect at the clock edge.

Top module: `tmr_chan_ctl`

## Requirements
- R1: After reset, configuration word 0 (offset 0x00) reads 0x00000101. Configuration word 1, the control word, all buffers and all counters read 0, and every expire output is low.
- R2: Offsets 0x00 and 0x04 hold configuration words. Channel n has its count buffer at 0x0C+12n. For n below 4 it also has a compare buffer at 0x10+12n and a counter view at 0x14+12n. Channel 4 has its counter view at 0x40. Counter views are read-only. Any other offset reads 0 and a write to it changes nothing.
- R3: The control word is at 0x08. Channel 0 uses bits 0 to 3, and channel n (n = 1 to 3) uses bits 4n+4 to 4n+7. The order inside each group is start, manual update, output invert, auto-reload. Channel 4 has start at bit 20, manual update at bit 21 and auto-reload at bit 22. Every other bit reads 0.
- R4: A control write that takes a manual-update bit from 0 to 1 copies that channel's count buffer into its counter. Writing the bit as 1 while it is already 1 loads nothing.
- R5: While a channel's start bit is 1, each tick lowers a nonzero count by one. A write that clears the start bit freezes the count.
- R6: A tick at count 0 on a running channel raises that channel's expire output for exactly one cycle, in the cycle after the tick.
- R7: An expiry with auto-reload set loads the count buffer and leaves the start bit at 1.
- R8: An expiry without auto-reload leaves the count at 0 and clears the channel's start bit in the control word.
- R9: A single write that raises both manual update and start loads the buffer and starts counting from the loaded value.
- R10: Ticks that arrive in the same cycle as a control-word write are ignored.
- R11: Channel 4 takes its auto-reload setting from bit 22.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tick | input | 5 | Per-channel count strobe |
| expire | output | 5 | Per-channel one-cycle expiry pulse |

## Verification
The bench checks that a manual-update bit held high does not reload a second time. A design that compared levels instead of edges would reload the counter on every control write. It checks that a channel without auto-reload, left ticking after expiry, stays at zero, gives exactly one pulse and shows a cleared start bit. A design that wrapped or kept the start bit set would give extra pulses. It checks a tick that lands on a control write; if the design counted it, the counter view would drop by one. It also checks channel 4's odd bit layout, the mask on the unused control bits, and that writes to the counter view or to unmapped offsets leave the read data unchanged.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int N_CH = 5;
  localparam int AW   = 8;
  localparam int DW   = 32;
  localparam logic [DW-1:0] CFG0_RST = 32'h0000_0101;
  localparam logic [AW-1:0] A_CFG0 = 8'h00;
  localparam logic [AW-1:0] A_CFG1 = 8'h04;
  localparam logic [AW-1:0] A_CTRL = 8'h08;

  // first bit of a channel's control group
  function automatic int grp_base(input int ch);
    return (ch == 0) ? 0 : 4 * ch + 4;
  endfunction
  function automatic int bit_start(input int ch);
    return grp_base(ch);
  endfunction
  function automatic int bit_upd(input int ch);
    return grp_base(ch) + 1;
  endfunction
  function automatic int bit_arl(input int ch);
    return (ch == N_CH - 1) ? 22 : grp_base(ch) + 3;
  endfunction
  function automatic logic [DW-1:0] ctrl_mask();
    logic [DW-1:0] m;
    m = '0;
    for (int c = 0; c < N_CH; c++) begin
      m[bit_start(c)] = 1'b1;
      m[bit_upd(c)]   = 1'b1;
      m[bit_arl(c)]   = 1'b1;
      if (c != N_CH - 1) m[grp_base(c) + 2] = 1'b1;
    end
    return m;
  endfunction

  // address map arithmetic
  function automatic logic [AW-1:0] a_cbuf(input int ch);
    return AW'(12 + 12 * ch);
  endfunction
  function automatic logic [AW-1:0] a_cmp(input int ch);
    return AW'(16 + 12 * ch);
  endfunction
  function automatic logic [AW-1:0] a_view(input int ch);
    return (ch == N_CH - 1) ? AW'(8'h40) : AW'(20 + 12 * ch);
  endfunction
endpackage

// File: rtl/tmr_bufregs.sv
module tmr_bufregs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [AW-1:0]                 addr,
  input  logic [DW-1:0]                 wdata,
  output logic [DW-1:0]                 cfg0_q,
  output logic [DW-1:0]                 cfg1_q,
  output logic [N_CH-1:0][CNT_W-1:0]    cbuf_q,
  output logic [N_CH-2:0][CNT_W-1:0]    cmp_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg0_q <= CFG0_RST;
      cfg1_q <= '0;
    end else if (we) begin
      if (addr == A_CFG0) cfg0_q <= wdata;
      if (addr == A_CFG1) cfg1_q <= wdata;
    end
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_cbuf
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cbuf_q[g] <= '0;
      else if (we && addr == a_cbuf(g)) cbuf_q[g] <= wdata[CNT_W-1:0];
    end
  end

  for (genvar g = 0; g < N_CH - 1; g++) begin : g_cmp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cmp_q[g] <= '0;
      else if (we && addr == a_cmp(g)) cmp_q[g] <= wdata[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/tmr_ctrl_word.sv
module tmr_ctrl_word
  import tmr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [DW-1:0]   wdata,
  input  logic [N_CH-1:0] clr_start,
  output logic [DW-1:0]   ctrl_q,
  output logic [N_CH-1:0] load,
  output logic [N_CH-1:0] run,
  output logic [N_CH-1:0] arl
);
  localparam logic [DW-1:0] MASK = ctrl_mask();
  logic [DW-1:0] clr_vec;

  for (genvar g = 0; g < N_CH; g++) begin : g_bits
    // rising manual-update edge: new value against stored value
    assign load[g] = we && wdata[bit_upd(g)] && !ctrl_q[bit_upd(g)];
    assign run[g]  = ctrl_q[bit_start(g)];
    assign arl[g]  = ctrl_q[bit_arl(g)];
  end

  always_comb begin
    clr_vec = '0;
    for (int c = 0; c < N_CH; c++) clr_vec[bit_start(c)] = clr_start[c];
  end

  // a software write wins over an expiry clearing a start bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctrl_q <= '0;
    else if (we) ctrl_q <= wdata & MASK;
    else         ctrl_q <= ctrl_q & ~clr_vec;
  end
endmodule

// File: rtl/tmr_down_cnt.sv
module tmr_down_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  input  logic             tick_en,
  input  logic             arl,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire_q,
  output logic             expire_now
);
  assign expire_now = run && tick_en && (cnt_q == '0) && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      expire_q <= 1'b0;
    end else begin
      expire_q <= expire_now;
      if (load)               cnt_q <= load_val;
      else if (expire_now)    cnt_q <= arl ? load_val : '0;
      else if (run && tick_en) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/tmr_rd_mux.sv
module tmr_rd_mux
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic [AW-1:0]               addr,
  input  logic [DW-1:0]               cfg0,
  input  logic [DW-1:0]               cfg1,
  input  logic [DW-1:0]               ctrl,
  input  logic [N_CH-1:0][CNT_W-1:0]  cbuf,
  input  logic [N_CH-2:0][CNT_W-1:0]  cmp,
  input  logic [N_CH-1:0][CNT_W-1:0]  cnt,
  output logic [DW-1:0]               rdata
);
  always_comb begin
    rdata = '0;
    if (addr == A_CFG0) rdata = cfg0;
    if (addr == A_CFG1) rdata = cfg1;
    if (addr == A_CTRL) rdata = ctrl;
    for (int c = 0; c < N_CH; c++) begin
      if (addr == a_cbuf(c)) rdata = DW'(cbuf[c]);
      if (addr == a_view(c)) rdata = DW'(cnt[c]);
    end
    for (int c = 0; c < N_CH - 1; c++)
      if (addr == a_cmp(c)) rdata = DW'(cmp[c]);
  end
endmodule

// File: rtl/tmr_chan_ctl.sv
module tmr_chan_ctl
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [N_CH-1:0] tick,
  output logic [N_CH-1:0] expire
);
  logic                         ctrl_we;
  logic [DW-1:0]                cfg0_q, cfg1_q, ctrl_q;
  logic [N_CH-1:0][CNT_W-1:0]   cbuf_q, cnt_q;
  logic [N_CH-2:0][CNT_W-1:0]   cmp_q;
  logic [N_CH-1:0]              load, run, arl, tick_en, expire_now;

  assign ctrl_we = bus_we && (bus_addr == A_CTRL);
  assign tick_en = tick & {N_CH{!ctrl_we}};

  tmr_bufregs #(.CNT_W(CNT_W)) bufs_i (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .cfg0_q(cfg0_q), .cfg1_q(cfg1_q), .cbuf_q(cbuf_q), .cmp_q(cmp_q)
  );

  tmr_ctrl_word ctrl_i (
    .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wdata(bus_wdata),
    .clr_start(expire_now & ~arl), .ctrl_q(ctrl_q),
    .load(load), .run(run), .arl(arl)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    tmr_down_cnt #(.CNT_W(CNT_W)) cnt_i (
      .clk(clk), .rst_n(rst_n), .load(load[g]), .load_val(cbuf_q[g]),
      .run(run[g]), .tick_en(tick_en[g]), .arl(arl[g]),
      .cnt_q(cnt_q[g]), .expire_q(expire[g]), .expire_now(expire_now[g])
    );
  end

  tmr_rd_mux #(.CNT_W(CNT_W)) rd_i (
    .addr(bus_addr), .cfg0(cfg0_q), .cfg1(cfg1_q), .ctrl(ctrl_q),
    .cbuf(cbuf_q), .cmp(cmp_q), .cnt(cnt_q), .rdata(bus_rdata)
  );
endmodule

// File: rtl/tmr_chan_ctl_chk.sv
module tmr_chan_ctl_chk
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        bus_we,
  input logic [AW-1:0]               bus_addr,
  input logic [DW-1:0]               bus_wdata,
  input logic [DW-1:0]               bus_rdata,
  input logic [N_CH-1:0]             tick,
  input logic [N_CH-1:0]             expire,
  input logic [DW-1:0]               ctrl_q,
  input logic [N_CH-1:0][CNT_W-1:0]  cnt_q,
  input logic [N_CH-1:0][CNT_W-1:0]  cbuf_q
);
  logic wr_c;
  assign wr_c = bus_we && (bus_addr == A_CTRL);

  // R2
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 8'h44) |-> (bus_rdata == '0));

  for (genvar g = 0; g < N_CH; g++) begin : g_p
    // R5
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_c && tick[g] && ctrl_q[bit_start(g)] && cnt_q[g] != '0)
      |=> (cnt_q[g] == $past(cnt_q[g]) - 1'b1));
    // R5
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_c && !ctrl_q[bit_start(g)]) |=> $stable(cnt_q[g]));
    // R6
    expire_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_c && tick[g] && ctrl_q[bit_start(g)] && cnt_q[g] == '0) |=> expire[g]);
    // R6
    expire_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!wr_c && tick[g] && ctrl_q[bit_start(g)] && cnt_q[g] == '0) |=> !expire[g]);
    // R7
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_c && tick[g] && ctrl_q[bit_start(g)] && ctrl_q[bit_arl(g)] && cnt_q[g] == '0)
      |=> (cnt_q[g] == $past(cbuf_q[g]) && ctrl_q[bit_start(g)]));
    // R8
    stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_c && tick[g] && ctrl_q[bit_start(g)] && !ctrl_q[bit_arl(g)] && cnt_q[g] == '0)
      |=> (cnt_q[g] == '0 && !ctrl_q[bit_start(g)]));
    // R4
    manual_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_c && bus_wdata[bit_upd(g)] && !ctrl_q[bit_upd(g)])
      |=> (cnt_q[g] == $past(cbuf_q[g])));
    // R10
    write_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_c && !(bus_wdata[bit_upd(g)] && !ctrl_q[bit_upd(g)])) |=> $stable(cnt_q[g]));
  end
endmodule

bind tmr_chan_ctl tmr_chan_ctl_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick), .expire(expire),
  .ctrl_q(ctrl_q), .cnt_q(cnt_q), .cbuf_q(cbuf_q)
);

// File: tb/tmr_chan_ctl_tb.sv
module tmr_chan_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;

  typedef struct packed {
    logic        we;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  // register-map vectors (R2, R3, R4); reads check exp
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'h00, 32'h0000_1234, 32'h0},
    '{1'b0, 8'h00, 32'h0,         32'h0000_1234},
    '{1'b1, 8'h04, 32'h0000_ABCD, 32'h0},
    '{1'b0, 8'h04, 32'h0,         32'h0000_ABCD},
    '{1'b1, 8'h10, 32'h0000_0055, 32'h0},
    '{1'b0, 8'h10, 32'h0,         32'h0000_0055},
    '{1'b1, 8'h34, 32'h0000_0077, 32'h0},
    '{1'b0, 8'h34, 32'h0,         32'h0000_0077},
    '{1'b1, 8'h0C, 32'h0000_0100, 32'h0},
    '{1'b0, 8'h0C, 32'h0,         32'h0000_0100},
    '{1'b1, 8'h3C, 32'hFFFF_FFFF, 32'h0},
    '{1'b0, 8'h3C, 32'h0,         32'hFFFF_FFFF},
    '{1'b1, 8'h44, 32'h0000_001F, 32'h0},
    '{1'b0, 8'h44, 32'h0,         32'h0},
    '{1'b1, 8'h14, 32'h0000_0099, 32'h0},
    '{1'b0, 8'h14, 32'h0,         32'h0},
    '{1'b1, 8'h08, 32'hFFFF_FFFF, 32'h0},
    '{1'b0, 8'h08, 32'h0,         32'h007F_FF0F},
    '{1'b0, 8'h14, 32'h0,         32'h0000_0100},
    '{1'b1, 8'h08, 32'h0,         32'h0}
  };

  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_we = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [4:0]  tick = 0;
  logic [4:0]  expire;
  int errors = 0;
  int checks = 0;
  int exp_cnt [5] = '{0, 0, 0, 0, 0};

  always #(CLK_PERIOD / 2) clk = ~clk;

  tmr_chan_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick), .expire(expire)
  );

  always @(negedge clk) for (int i = 0; i < 5; i++) if (expire[i]) exp_cnt[i]++;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] want);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, want);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_we = 0; bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic ticks(input logic [4:0] m, input int n);
    @(negedge clk);
    tick = m;
    repeat (n) @(negedge clk);
    tick = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int b0, b1, b4;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 expire", 32'(expire), 32'h0);
    rd(8'h00, v); chk("R1 cfg0", v, 32'h0000_0101);
    rd(8'h08, v); chk("R1 ctrl", v, 32'h0);
    rd(8'h40, v); chk("R1 view4", v, 32'h0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].we) wr(VEC[i].addr, VEC[i].data);
      else begin
        rd(VEC[i].addr, v);
        chk($sformatf("R2/R3/R4 vec%0d", i), v, VEC[i].exp);
      end
    end

    // R4 R5 R6 R8: channel 0, no auto-reload
    wr(8'h0C, 32'd3);
    wr(8'h08, 32'h2);
    rd(8'h14, v); chk("R4 load ch0", v, 32'd3);
    wr(8'h08, 32'h1);
    b0 = exp_cnt[0];
    ticks(5'b00001, 2);
    rd(8'h14, v); chk("R5 count ch0", v, 32'd1);
    ticks(5'b00001, 6);
    rd(8'h14, v); chk("R8 rest at zero", v, 32'd0);
    chk("R6 one pulse", 32'(exp_cnt[0] - b0), 32'd1);
    rd(8'h08, v); chk("R8 start cleared", v, 32'h0);

    // R7 R5: channel 1 auto-reload
    wr(8'h18, 32'd2);
    wr(8'h08, 32'h0A00);
    wr(8'h08, 32'h0900);
    b1 = exp_cnt[1];
    ticks(5'b00010, 3);
    rd(8'h20, v); chk("R7 reload value", v, 32'd2);
    chk("R7 first expiry", 32'(exp_cnt[1] - b1), 32'd1);
    ticks(5'b00010, 4);
    chk("R7 second expiry", 32'(exp_cnt[1] - b1), 32'd2);
    rd(8'h08, v); chk("R7 start kept", v, 32'h0900);
    wr(8'h08, 32'h0800);
    ticks(5'b00010, 5);
    rd(8'h20, v); chk("R5 frozen after stop", v, 32'd1);

    // R11: channel 4 auto-reload at bit 22
    wr(8'h3C, 32'd1);
    wr(8'h08, 32'h0020_0000);
    rd(8'h40, v); chk("R11 load ch4", v, 32'd1);
    wr(8'h08, 32'h0050_0000);
    b4 = exp_cnt[4];
    ticks(5'b10000, 2);
    rd(8'h40, v); chk("R11 reload ch4", v, 32'd1);
    chk("R11 expiry ch4", 32'(exp_cnt[4] - b4), 32'd1);
    rd(8'h08, v); chk("R11 start kept", v, 32'h0050_0000);

    // R4: held manual-update bit does not reload
    wr(8'h24, 32'd5);
    wr(8'h08, 32'h2000);
    wr(8'h24, 32'd9);
    wr(8'h08, 32'h2000);
    rd(8'h2C, v); chk("R4 no level reload", v, 32'd5);
    wr(8'h08, 32'h0);
    wr(8'h08, 32'h2000);
    rd(8'h2C, v); chk("R4 new edge reload", v, 32'd9);

    // R9 R10: channel 3
    wr(8'h30, 32'd4);
    wr(8'h08, 32'h0003_0000);
    ticks(5'b01000, 1);
    rd(8'h38, v); chk("R9 load and run", v, 32'd3);
    @(negedge clk);
    bus_we = 1; bus_addr = 8'h08; bus_wdata = 32'h0003_0000; tick = 5'b01000;
    @(negedge clk);
    bus_we = 0; tick = 0;
    rd(8'h38, v); chk("R10 tick on write ignored", v, 32'd3);
    ticks(5'b01000, 1);
    rd(8'h38, v); chk("R10 still running", v, 32'd2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule